// File: doc/BRIEF.md
# Dual-Channel Parallel DAC Bus Host Controller

This block sits in a host chip and turns simple commands into bus cycles for an external dual-channel, 12-bit, parallel-input DAC. A command carries a direction bit, a channel bit and a data word. It is offered with a valid/ready handshake. The controller then runs one bus cycle with the timing the converter needs. It drives an active-low chip select, a read/write line, a channel-select line and the data bus. The data bus is split into an output word, an output enable and an input word, and the pad ring joins them into the bidirectional pins.

Every timing limit is a parameter counted in system clock cycles: the address setup before a write strobe, the minimum strobe width, the data setup before the strobe's trailing edge, the minimum chip-select high time, the read/write-high lead before a read strobe, the read access time and the bus release time after a read. A read samples the returned word at the end of its strobe and presents it with a one-cycle valid pulse. The DAC load strobe, clear and the analog side are outside this block.

Top module: `dacbus_ctrl`

## Requirements
- R1: While reset is active and right after it is released, bus_cs_n=1, bus_rw=1, bus_oe=0, cmd_ready=1 and rd_valid=0.
- R2: In a write cycle (cmd_write=1), bus_chan, bus_rw=0 and bus_dout are stable for at least T_ADDR_SETUP cycles before bus_cs_n falls.
- R3: In a write, bus_cs_n stays low for at least T_WR_LOW cycles. bus_dout holds a stable value for at least T_DATA_SETUP cycles before bus_cs_n rises, and chan/rw/dout do not change while bus_cs_n is low.
- R4: Between two strobes, bus_cs_n stays high for at least T_GAP cycles.
- R5: In a read (cmd_write=0), bus_rw=1 for at least T_RD_SETUP cycles before bus_cs_n falls and stays 1 while bus_cs_n is low.
- R6: A read samples bus_din exactly T_ACCESS cycles after bus_cs_n falls. The sampled word appears on rd_data with a single-cycle rd_valid pulse in the cycle after bus_cs_n rises. Writes never raise rd_valid.
- R7: After a read strobe ends, bus_oe stays low for at least T_RELEASE cycles.
- R8: bus_oe is high only during write cycles and never while bus_rw=1.
- R9: cmd_ready is low from acceptance until the final chip-select-high time has elapsed. A write keeps it low for max(T_ADDR_SETUP,1)+max(T_WR_LOW,T_DATA_SETUP,1)+max(T_GAP,1) cycles, and a read for max(T_RD_SETUP,1)+max(T_ACCESS,1)+max(T_GAP,T_RELEASE,1) cycles.
- R10: bus_chan equals the command's channel bit (0 or 1), so data written to one channel is read back from that channel and leaves the other channel unchanged.
- R11: A command held valid is accepted on the first cycle cmd_ready is high, so back-to-back commands lose no cycle beyond the recovery time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Controller idle, command accepted when valid |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_chan | input | 1 | Target channel (0 or 1) |
| cmd_data | input | DW | Write data |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | DW | Word captured by the last read |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_chan | output | 1 | Channel select |
| bus_dout | output | DW | Data driven toward the DAC |
| bus_oe | output | 1 | Output enable for the data pads |
| bus_din | input | DW | Data returned from the DAC pads |

## Verification
Each of the two channels is written with all-zero, all-one, alternating, mid-scale-neighbour and walking-one words, then read back. This shows stuck, swapped or shifted data bits and any mix-up of the channels. A reading of the untouched channel after each write separates a wrong channel select from a wrong data path. The DAC model in the bench returns garbage until the access time has passed, so a capture one cycle early shows up as a wrong word. Commands are issued back to back, so the write-after-read and read-after-write pairs exercise the release gap, the busy length and the chip-select high time.

// File: rtl/dacbus_pkg.sv
package dacbus_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SETUP   = 2'd1,
    PH_STROBE  = 2'd2,
    PH_RECOVER = 2'd3
  } phase_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dacbus_seq.sv
module dacbus_seq
  import dacbus_pkg::*;
#(
  parameter int S_WR = 2,
  parameter int L_WR = 2,
  parameter int R_WR = 2,
  parameter int S_RD = 1,
  parameter int L_RD = 7,
  parameter int R_RD = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   start_wr,
  input  logic   wr_q,
  output phase_e phase,
  output logic   last
);

  localparam int MAXL = imax(imax(imax(S_WR, L_WR), imax(R_WR, S_RD)), imax(L_RD, R_RD));
  localparam int CW   = $clog2(MAXL + 1);

  phase_e        phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_d = PH_SETUP;
          cnt_d   = start_wr ? CW'(S_WR - 1) : CW'(S_RD - 1);
        end
      end
      PH_SETUP: begin
        if (cnt_zero) begin
          phase_d = PH_STROBE;
          cnt_d   = wr_q ? CW'(L_WR - 1) : CW'(L_RD - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_STROBE: begin
        if (cnt_zero) begin
          phase_d = PH_RECOVER;
          cnt_d   = wr_q ? CW'(R_WR - 1) : CW'(R_RD - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_RECOVER: begin
        if (cnt_zero) begin
          phase_d = PH_IDLE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: begin
        phase_d = PH_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign phase = phase_q;
  assign last  = cnt_zero;

endmodule

// File: rtl/dacbus_cmd_reg.sv
module dacbus_cmd_reg #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          wr_in,
  input  logic          chan_in,
  input  logic [DW-1:0] data_in,
  output logic          wr_q,
  output logic          chan_q,
  output logic [DW-1:0] data_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      chan_q <= 1'b0;
      data_q <= '0;
    end else if (load) begin
      wr_q   <= wr_in;
      chan_q <= chan_in;
      data_q <= data_in;
    end
  end

endmodule

// File: rtl/dacbus_rd_capture.sv
module dacbus_rd_capture #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample,
  input  logic [DW-1:0] din,
  output logic          valid,
  output logic [DW-1:0] data
);

  logic          valid_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= sample;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (sample) begin
      data_q <= din;
    end
  end

  assign valid = valid_q;
  assign data  = data_q;

endmodule

// File: rtl/dacbus_ctrl.sv
module dacbus_ctrl
  import dacbus_pkg::*;
#(
  parameter int DW           = 12,
  parameter int T_ADDR_SETUP = 2,
  parameter int T_WR_LOW     = 2,
  parameter int T_DATA_SETUP = 2,
  parameter int T_GAP        = 2,
  parameter int T_RD_SETUP   = 1,
  parameter int T_ACCESS     = 7,
  parameter int T_RELEASE    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_write,
  input  logic          cmd_chan,
  input  logic [DW-1:0] cmd_data,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          bus_cs_n,
  output logic          bus_rw,
  output logic          bus_chan,
  output logic [DW-1:0] bus_dout,
  output logic          bus_oe,
  input  logic [DW-1:0] bus_din
);

  // Phase lengths in cycles, each at least one.
  localparam int S_WR = imax(T_ADDR_SETUP, 1);
  localparam int L_WR = imax(imax(T_WR_LOW, T_DATA_SETUP), 1);
  localparam int R_WR = imax(T_GAP, 1);
  localparam int S_RD = imax(T_RD_SETUP, 1);
  localparam int L_RD = imax(T_ACCESS, 1);
  localparam int R_RD = imax(imax(T_GAP, T_RELEASE), 1);

  phase_e        phase;
  logic          last;
  logic          accept;
  logic          wr_q;
  logic          chan_q;
  logic [DW-1:0] data_q;
  logic          busy;
  logic          sample;

  assign cmd_ready = (phase == PH_IDLE);
  assign accept    = cmd_valid && cmd_ready;

  dacbus_seq #(
    .S_WR(S_WR), .L_WR(L_WR), .R_WR(R_WR),
    .S_RD(S_RD), .L_RD(L_RD), .R_RD(R_RD)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .start_wr (cmd_write),
    .wr_q     (wr_q),
    .phase    (phase),
    .last     (last)
  );

  dacbus_cmd_reg #(.DW(DW)) u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .wr_in   (cmd_write),
    .chan_in (cmd_chan),
    .data_in (cmd_data),
    .wr_q    (wr_q),
    .chan_q  (chan_q),
    .data_q  (data_q)
  );

  assign sample = (phase == PH_STROBE) && last && !wr_q;

  dacbus_rd_capture #(.DW(DW)) u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .sample (sample),
    .din    (bus_din),
    .valid  (rd_valid),
    .data   (rd_data)
  );

  assign busy     = (phase != PH_IDLE);
  assign bus_cs_n = (phase != PH_STROBE);
  assign bus_rw   = !(busy && wr_q);
  assign bus_oe   = busy && wr_q;
  assign bus_chan = chan_q;
  assign bus_dout = data_q;

endmodule

// File: rtl/dacbus_ctrl_chk.sv
module dacbus_ctrl_chk #(
  parameter int DW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_ready,
  input logic          rd_valid,
  input logic          bus_cs_n,
  input logic          bus_rw,
  input logic          bus_chan,
  input logic [DW-1:0] bus_dout,
  input logic          bus_oe
);

  a_r3_hold_while_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_cs_n && $past(!bus_cs_n)) |-> ($stable(bus_dout) && $stable(bus_chan) && $stable(bus_rw)));

  a_r2_chan_set_before_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_cs_n) |-> ($stable(bus_chan) && $stable(bus_rw)));

  a_r4_high_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_cs_n) |=> bus_cs_n);

  a_r6_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($rose(bus_cs_n) && bus_rw));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  a_r8_oe_only_write: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> !bus_rw);

  a_r9_busy_during_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_cs_n |-> !cmd_ready);

endmodule

bind dacbus_ctrl dacbus_ctrl_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_ready (cmd_ready),
  .rd_valid  (rd_valid),
  .bus_cs_n  (bus_cs_n),
  .bus_rw    (bus_rw),
  .bus_chan  (bus_chan),
  .bus_dout  (bus_dout),
  .bus_oe    (bus_oe)
);

// File: tb/dacbus_ctrl_tb.sv
`timescale 1ns/1ps
module dacbus_ctrl_tb;

  localparam int DW    = 12;
  localparam int P_AS  = 2;
  localparam int P_CL  = 2;
  localparam int P_DS  = 3;
  localparam int P_CH  = 2;
  localparam int P_RS  = 1;
  localparam int P_ACC = 4;
  localparam int P_RQ  = 3;
  localparam int WR_BUSY = P_AS + ((P_CL > P_DS) ? P_CL : P_DS) + P_CH;
  localparam int RD_BUSY = P_RS + P_ACC + ((P_CH > P_RQ) ? P_CH : P_RQ);
  localparam int RDV_IDX = P_RS + P_ACC + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_write = 1'b0;
  logic          cmd_chan = 1'b0;
  logic [DW-1:0] cmd_data = '0;
  logic          cmd_ready, rd_valid, bus_cs_n, bus_rw, bus_chan, bus_oe;
  logic [DW-1:0] rd_data, bus_dout, bus_din;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  dacbus_ctrl #(
    .DW(DW), .T_ADDR_SETUP(P_AS), .T_WR_LOW(P_CL), .T_DATA_SETUP(P_DS),
    .T_GAP(P_CH), .T_RD_SETUP(P_RS), .T_ACCESS(P_ACC), .T_RELEASE(P_RQ)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_chan(cmd_chan), .cmd_data(cmd_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .bus_cs_n(bus_cs_n), .bus_rw(bus_rw),
    .bus_chan(bus_chan), .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_din(bus_din)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // DAC device model: two registers, slow read access
  logic [DW-1:0] dev_mem [2];
  logic [DW-1:0] exp_mem [2];
  int            lowcnt;

  always @(posedge clk) begin
    if (bus_cs_n) lowcnt <= 0;
    else          lowcnt <= lowcnt + 1;
  end

  assign bus_din = (!bus_cs_n && bus_rw && lowcnt >= P_ACC - 1) ? dev_mem[bus_chan]
                                                                 : ~dev_mem[bus_chan];

  // Bus timing monitor, sampled at falling edges
  logic          p_cs, p_rw, p_chan;
  logic [DW-1:0] p_dout;
  int stab, rwhi, lowc, highc, relq;
  bit seen, low_bad;

  always @(negedge clk) begin
    if (!rst_n) begin
      p_cs = 1'b1; p_rw = 1'b1; p_chan = 1'b0; p_dout = '0;
      stab = 0; rwhi = 0; lowc = 0; highc = 0; relq = 0; seen = 0; low_bad = 0;
    end else begin
      if (bus_chan == p_chan && bus_rw == p_rw && bus_dout == p_dout) stab++;
      else stab = 1;
      if (bus_rw) rwhi++; else rwhi = 0;
      chk(!(bus_oe && bus_rw), "R8 oe with rw high", bus_oe, 0);
      if (relq > 0) begin
        chk(!bus_oe, "R7 oe inside release window", bus_oe, 0);
        relq--;
      end
      if (p_cs && !bus_cs_n) begin
        if (!bus_rw) chk(stab - 1 >= P_AS, "R2 addr setup", stab - 1, P_AS);
        else         chk(rwhi - 1 >= P_RS, "R5 rw lead", rwhi - 1, P_RS);
        if (seen)    chk(highc >= P_CH, "R4 cs high time", highc, P_CH);
        lowc = 1; low_bad = 0; seen = 1;
      end else if (!p_cs && !bus_cs_n) begin
        lowc++;
        if (bus_chan != p_chan || bus_rw != p_rw || bus_dout != p_dout) low_bad = 1;
      end else if (!p_cs && bus_cs_n) begin
        chk(!low_bad, p_rw ? "R5 rw/chan moved in strobe" : "R3 bus moved in strobe", low_bad, 0);
        if (!p_rw) begin
          chk(lowc >= P_CL, "R3 strobe width", lowc, P_CL);
          chk(stab - 1 >= P_DS, "R3 data setup", stab - 1, P_DS);
          dev_mem[p_chan] = p_dout;
        end else begin
          chk(lowc == P_ACC, "R6 read strobe length", lowc, P_ACC);
          relq = P_RQ;
        end
        highc = 1;
      end else begin
        highc++;
      end
      p_cs = bus_cs_n; p_rw = bus_rw; p_chan = bus_chan; p_dout = bus_dout;
    end
  end

  task automatic issue(input bit wr, input bit ch, input logic [DW-1:0] d,
                       output int busy, output int rdv_at, output logic [DW-1:0] rdd);
    cmd_valid = 1'b1; cmd_write = wr; cmd_chan = ch; cmd_data = d;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    busy = 0; rdv_at = 0; rdd = '0;
    while (!cmd_ready) begin
      busy++;
      if (bus_cs_n == 1'b0) chk(bus_chan == ch, "R10 channel select", bus_chan, ch);
      if (rd_valid) begin rdv_at = busy; rdd = rd_data; end
      @(negedge clk);
    end
  endtask

  task automatic do_write(input bit ch, input logic [DW-1:0] d);
    int b, v; logic [DW-1:0] r;
    issue(1'b1, ch, d, b, v, r);
    exp_mem[ch] = d;
    chk(b == WR_BUSY, "R9 write busy length", b, WR_BUSY);
    chk(v == 0, "R6 no valid on write", v, 0);
  endtask

  task automatic do_read(input bit ch);
    int b, v; logic [DW-1:0] r;
    issue(1'b0, ch, '0, b, v, r);
    chk(b == RD_BUSY, "R9 R11 read busy length", b, RD_BUSY);
    chk(v == RDV_IDX, "R6 valid timing", v, RDV_IDX);
    chk(r == exp_mem[ch], "R6 R10 readback data", r, exp_mem[ch]);
  endtask

  function automatic logic [DW-1:0] pat(input int i);
    case (i)
      0: return '0;
      1: return '1;
      2: return 12'h555;
      3: return 12'hAAA;
      4: return 12'h800;
      5: return 12'h7FF;
      default: return DW'(1) << (i - 6);
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    dev_mem[0] = '0; dev_mem[1] = '0;
    exp_mem[0] = '0; exp_mem[1] = '0;
    repeat (3) @(negedge clk);
    chk(bus_cs_n && bus_rw && !bus_oe && cmd_ready && !rd_valid, "R1 reset outputs",
        {bus_cs_n, bus_rw, bus_oe, cmd_ready, rd_valid}, 5'b11010);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bus_cs_n && bus_rw && !bus_oe && cmd_ready && !rd_valid, "R1 after release",
        {bus_cs_n, bus_rw, bus_oe, cmd_ready, rd_valid}, 5'b11010);
    do_read(1'b0);
    do_read(1'b1);
    for (int ch = 0; ch < 2; ch++) begin
      for (int i = 0; i < 6 + DW; i++) begin
        do_write(ch[0], pat(i));
        do_read(ch[0]);
        do_read(~ch[0]);
      end
    end
    for (int i = 0; i < 8; i++) begin
      do_write(i[0], pat(i + 9) ^ 12'h3C3);
      do_write(~i[0], pat(i));
    end
    do_read(1'b0);
    do_read(1'b1);
    repeat (4) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule